// File: doc/BRIEF.md
# Round-Robin Output Refresh Sequencer

This block shares one DAC among a bank of held analog outputs. A refresh clock steps a channel pointer through the outputs, one channel per clock. On each step the block presents the selected channel's code to the DAC. It closes that channel's sample switch for the low half of the refresh clock and opens it again when the clock goes high, so the external hold capacitor keeps the level between visits.

Target codes arrive as a flat array and are captured as a whole by a single-cycle update strobe. There is no back-pressure: a strobe is accepted in any cycle, and the codes on the bus in that cycle take effect from that edge. Each channel keeps the code it was last given. On a visit, that code moves toward the captured target by at most a fixed step. When the remaining gap is no larger than the step, the code lands exactly on the target. A large swing is therefore spread over several rotations.

The refresh clock comes from one of two sources. One is an internal oscillator divided from the system clock. The other is an external clock input, synchronised to the system clock. The change between them happens only at a point where both sources are low. The common-voltage code is either driven straight from the captured value (the default) or refreshed as an extra slot in the rotation.

Top module: `refresh_sequencer`

## Requirements
- R1: After reset `chan_idx` is N_SLOT-1 (17 by default). On each falling refresh edge it advances by one, wrapping from N_SLOT-1 to 0, so every channel is revisited every N_SLOT refresh clocks.
- R2: `sw_en` has at most one bit set. When it is nonzero, bit `chan_idx` is the set bit. It is set after a falling refresh edge and cleared after the following rising edge.
- R3: A pulse on `update` captures all of `codes_in`. Channel k occupies bits [k*CODE_W +: CODE_W], and entry N_GAMMA holds the common-voltage code. A channel whose change is within one step shows its new code within N_SLOT+1 refresh clocks. Changes on `codes_in` without `update` have no effect.
- R4: On a visit, a channel's applied code, shown on `dac_code`, moves toward its target by at most STEP codes (default 372).
- R5: When the gap between the applied code and the target is at most STEP, the visit sets the applied code equal to the target.
- R6: Reset leaves `dac_code` at 0, `sw_en` at 0, the internal source selected, and `osc_oe` low unless `share_osc` is high.
- R7: With `ext_mode` high, the refresh clock follows `ext_clk` (one channel step per external period), and `osc_oe` is low.
- R8: With `ext_mode` low and `share_osc` high, `osc_oe` is high. `osc_out` carries the internal oscillator, with OSC_HALF system clocks per phase.
- R9: The selected clock source changes only in a cycle where both the internal oscillator and the synchronised external clock are low.
- R10: With VCOM_ROTATE = 0, `vcom_code` equals the captured common-voltage code one cycle after `update`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| codes_in | input | (N_GAMMA+1)*CODE_W | Target code array, channel k in slice k |
| update | input | 1 | Capture strobe for `codes_in` |
| ext_clk | input | 1 | External refresh clock |
| ext_mode | input | 1 | 1 selects the external clock, 0 the internal one |
| share_osc | input | 1 | Request to drive the internal oscillator out |
| dac_code | output | CODE_W | Code of the channel being refreshed |
| chan_idx | output | IDX_W | Index of the channel being refreshed |
| sw_en | output | N_SLOT | Per-channel sample switch enables |
| vcom_code | output | CODE_W | Common-voltage code |
| osc_out | output | 1 | Internal oscillator for the clock pin |
| osc_oe | output | 1 | Output enable of the clock pin (0 = high impedance) |

## Verification
The hardest behaviour to reach is the slew walk. It shows only when a channel's target sits several steps away from its applied code, and it takes several full rotations to settle. The stimulus jumps every channel from 0 to full scale and back down to a mid code. The bench then follows each visit, predicting each intermediate code from the step rule. The clock source change is the other hard case. The bench turns on a free-running external clock, flips `ext_mode` while both sources run, and counts channel steps per external period.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef logic [15:0] code_t;

  // Move cur toward tgt by at most step; land on tgt when close enough.
  function automatic code_t slew_step(code_t cur, code_t tgt, code_t step);
    if (tgt > cur) return ((tgt - cur) > step) ? code_t'(cur + step) : tgt;
    else           return ((cur - tgt) > step) ? code_t'(cur - step) : tgt;
  endfunction
endpackage

// File: rtl/refresh_clk_sel.sv
module refresh_clk_sel #(
  parameter int OSC_HALF = 4762
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic ext_mode,
  output logic int_osc,
  output logic ext_s,
  output logic src_sel,
  output logic rise,
  output logic fall
);
  localparam int CNT_W = $clog2(OSC_HALF + 1);

  logic [CNT_W-1:0] cnt;
  logic ext_m, mode_q, rclk, rclk_q, rclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; int_osc <= 1'b0;
    end else if (cnt == CNT_W'(OSC_HALF - 1)) begin
      cnt <= '0; int_osc <= ~int_osc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_m <= 1'b0; ext_s <= 1'b0; mode_q <= 1'b0; src_sel <= 1'b0;
    end else begin
      ext_m  <= ext_clk;
      ext_s  <= ext_m;
      mode_q <= ext_mode;
      if (!int_osc && !ext_s) src_sel <= mode_q;
    end
  end

  assign rclk = src_sel ? ext_s : int_osc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rclk_q <= 1'b0; rclk_d <= 1'b0;
    end else begin
      rclk_q <= rclk; rclk_d <= rclk_q;
    end
  end

  assign rise = rclk_q & ~rclk_d;
  assign fall = ~rclk_q & rclk_d;
endmodule

// File: rtl/refresh_rotor.sv
module refresh_rotor #(
  parameter int N_SLOT = 18,
  localparam int IDX_W = $clog2(N_SLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] nxt,
  output logic [N_SLOT-1:0] sw_en
);
  assign nxt = (idx == IDX_W'(N_SLOT - 1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= IDX_W'(N_SLOT - 1);
      sw_en <= '0;
    end else if (fall) begin
      idx   <= nxt;
      sw_en <= N_SLOT'(1) << nxt;
    end else if (rise) begin
      sw_en <= '0;
    end
  end
endmodule

// File: rtl/refresh_slew.sv
module refresh_slew
  import refresh_pkg::*;
#(
  parameter int N_GAMMA     = 18,
  parameter int CODE_W      = 11,
  parameter int STEP        = 372,
  parameter bit VCOM_ROTATE = 1'b0,
  localparam int N_SLOT = N_GAMMA + int'(VCOM_ROTATE),
  localparam int N_REG  = N_GAMMA + 1,
  localparam int IDX_W  = $clog2(N_SLOT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    update,
  input  logic [N_REG*CODE_W-1:0] codes_in,
  input  logic                    fall,
  input  logic [IDX_W-1:0]        nxt,
  output logic [CODE_W-1:0]       dac_code,
  output logic [CODE_W-1:0]       vcom_code,
  output logic [N_SLOT*CODE_W-1:0] app_flat
);
  logic [CODE_W-1:0] shadow [N_REG];
  logic [CODE_W-1:0] tgt_eff [N_REG];
  logic [CODE_W-1:0] applied [N_SLOT];
  logic [CODE_W-1:0] stepped;

  always_comb begin
    for (int k = 0; k < N_REG; k++)
      tgt_eff[k] = update ? codes_in[k*CODE_W +: CODE_W] : shadow[k];
  end

  assign stepped = CODE_W'(slew_step(code_t'(applied[nxt]), code_t'(tgt_eff[nxt]),
                                     code_t'(STEP)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_REG; k++) shadow[k] <= '0;
      for (int k = 0; k < N_SLOT; k++) applied[k] <= '0;
      dac_code <= '0;
    end else begin
      if (update)
        for (int k = 0; k < N_REG; k++) shadow[k] <= codes_in[k*CODE_W +: CODE_W];
      if (fall) begin
        applied[nxt] <= stepped;
        dac_code     <= stepped;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < N_SLOT; k++) app_flat[k*CODE_W +: CODE_W] = applied[k];
  end

  generate
    if (VCOM_ROTATE) begin : g_vcom_slot
      assign vcom_code = applied[N_GAMMA];
    end else begin : g_vcom_direct
      assign vcom_code = shadow[N_GAMMA];
    end
  endgenerate
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
  parameter int N_GAMMA     = 18,
  parameter int CODE_W      = 11,
  parameter int STEP        = 372,
  parameter int OSC_HALF    = 4762,
  parameter bit VCOM_ROTATE = 1'b0,
  localparam int N_SLOT = N_GAMMA + int'(VCOM_ROTATE),
  localparam int N_REG  = N_GAMMA + 1,
  localparam int IDX_W  = $clog2(N_SLOT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REG*CODE_W-1:0] codes_in,
  input  logic                    update,
  input  logic                    ext_clk,
  input  logic                    ext_mode,
  input  logic                    share_osc,
  output logic [CODE_W-1:0]       dac_code,
  output logic [IDX_W-1:0]        chan_idx,
  output logic [N_SLOT-1:0]       sw_en,
  output logic [CODE_W-1:0]       vcom_code,
  output logic                    osc_out,
  output logic                    osc_oe
);
  logic int_osc, ext_s, src_sel, rise, fall;
  logic [IDX_W-1:0] nxt;
  logic [N_SLOT*CODE_W-1:0] app_flat;

  refresh_clk_sel #(.OSC_HALF(OSC_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_mode(ext_mode),
    .int_osc(int_osc), .ext_s(ext_s), .src_sel(src_sel), .rise(rise), .fall(fall)
  );

  refresh_rotor #(.N_SLOT(N_SLOT)) u_rot (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .idx(chan_idx), .nxt(nxt), .sw_en(sw_en)
  );

  refresh_slew #(.N_GAMMA(N_GAMMA), .CODE_W(CODE_W), .STEP(STEP),
                 .VCOM_ROTATE(VCOM_ROTATE)) u_slew (
    .clk(clk), .rst_n(rst_n), .update(update), .codes_in(codes_in),
    .fall(fall), .nxt(nxt), .dac_code(dac_code), .vcom_code(vcom_code),
    .app_flat(app_flat)
  );

  assign osc_out = int_osc;
  assign osc_oe  = share_osc & ~src_sel;
endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk #(
  parameter int N_SLOT = 18,
  parameter int CODE_W = 11,
  parameter int STEP   = 372,
  localparam int IDX_W = $clog2(N_SLOT)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [IDX_W-1:0]         chan_idx,
  input logic [N_SLOT-1:0]        sw_en,
  input logic [CODE_W-1:0]        dac_code,
  input logic                     osc_oe,
  input logic                     src_sel,
  input logic                     int_osc,
  input logic                     ext_s,
  input logic [N_SLOT*CODE_W-1:0] app_flat
);
  logic [N_SLOT*CODE_W-1:0] app_d;
  logic [CODE_W-1:0] prev_code;
  logic [CODE_W:0]   gap;
  logic [IDX_W-1:0]  idx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_d <= '0; idx_d <= IDX_W'(N_SLOT - 1);
    end else begin
      app_d <= app_flat; idx_d <= chan_idx;
    end
  end

  always_comb begin
    prev_code = app_d[chan_idx*CODE_W +: CODE_W];
    gap = (dac_code > prev_code) ? {1'b0, dac_code} - {1'b0, prev_code}
                                 : {1'b0, prev_code} - {1'b0, dac_code};
  end

  a_r1_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_idx != idx_d) |->
      (chan_idx == ((idx_d == IDX_W'(N_SLOT - 1)) ? '0 : idx_d + 1'b1)));

  a_r2_sw_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en));

  a_r2_sw_matches_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en != '0) |-> sw_en[chan_idx]);

  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_idx != idx_d) |-> (gap <= (CODE_W+1)'(STEP)));

  a_r7_oe_internal_only: assert property (@(posedge clk) disable iff (!rst_n)
    osc_oe |-> !src_sel);

  a_r9_swap_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |-> (!$past(int_osc) && !$past(ext_s)));
endmodule

bind refresh_sequencer refresh_sequencer_chk #(
  .N_SLOT(N_SLOT), .CODE_W(CODE_W), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_idx(chan_idx), .sw_en(sw_en),
  .dac_code(dac_code), .osc_oe(osc_oe), .src_sel(src_sel),
  .int_osc(int_osc), .ext_s(ext_s), .app_flat(app_flat)
);

// File: tb/refresh_sequencer_bench.sv
`timescale 1ns/1ps
module refresh_sequencer_bench;
  localparam int CH = 18, CW = 11, STEP = 372, HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic update = 1'b0, ext_clk = 1'b0, ext_mode = 1'b0, share_osc = 1'b0;
  logic ext_run = 1'b0;
  logic [CW-1:0] tgt [CH+1];
  logic [(CH+1)*CW-1:0] codes_in;
  logic [CW-1:0] dac_code, vcom_code;
  logic [4:0] chan_idx;
  logic [CH-1:0] sw_en;
  logic osc_out, osc_oe;

  int checks = 0, errors = 0, visits = 0;
  logic mon_en = 1'b0;
  int model_app [CH], tgt_model [CH+1], obs [CH];
  int prev_idx;

  always #2.5 clk = ~clk;

  always begin
    if (ext_run) begin
      repeat (20) @(posedge clk); ext_clk = ~ext_clk;
    end else @(posedge clk);
  end

  always_comb
    for (int k = 0; k <= CH; k++) codes_in[k*CW +: CW] = tgt[k];

  refresh_sequencer #(.N_GAMMA(CH), .CODE_W(CW), .STEP(STEP), .OSC_HALF(HALF))
    u_refresh_sequencer (.clk(clk), .rst_n(rst_n), .codes_in(codes_in),
      .update(update), .ext_clk(ext_clk), .ext_mode(ext_mode),
      .share_osc(share_osc), .dac_code(dac_code), .chan_idx(chan_idx),
      .sw_en(sw_en), .vcom_code(vcom_code), .osc_out(osc_out), .osc_oe(osc_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int next_code(int cur, int t);
    if (t - cur > STEP) return cur + STEP;
    if (cur - t > STEP) return cur - STEP;
    return t;
  endfunction

  // Visit monitor: order (R1) and per-visit slew prediction (R4, R5)
  always @(negedge clk) begin
    if (mon_en && int'(chan_idx) != prev_idx) begin
      int c, e;
      c = int'(chan_idx);
      check(c == ((prev_idx + 1) % CH), "R1 order", c, (prev_idx + 1) % CH);
      e = next_code(model_app[c], tgt_model[c]);
      check(int'(dac_code) == e, "R4/R5 visit code", int'(dac_code), e);
      model_app[c] = e;
      obs[c] = int'(dac_code);
      prev_idx = c;
      visits++;
    end
  end

  task automatic wait_visits(input int n);
    int start;
    start = visits;
    while (visits < start + n) @(negedge clk);
  endtask

  task automatic do_update();
    @(negedge clk); #1;
    update = 1'b1;
    for (int k = 0; k <= CH; k++) tgt_model[k] = int'(tgt[k]);
    @(negedge clk); #1;
    update = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(dac_code == '0, "R6 dac", int'(dac_code), 0);
    check(sw_en == '0, "R6 sw_en", int'(sw_en), 0);
    check(osc_oe == 1'b0, "R6 oe", int'(osc_oe), 0);
    check(int'(chan_idx) == CH - 1, "R1 reset idx", int'(chan_idx), CH - 1);
  endtask

  task automatic t_switches();
    int hi_run = 0, seen = 0;
    share_osc = 1'b1;
    repeat (3 * CH * 2 * HALF) begin
      @(negedge clk);
      hi_run = osc_out ? hi_run + 1 : 0;
      if (sw_en != '0) begin
        seen++;
        check(sw_en == (CH'(1) << chan_idx), "R2 switch matches index",
              int'(sw_en), 1 << chan_idx);
      end
      if (hi_run >= 3) check(sw_en == '0, "R2 open while high", int'(sw_en), 0);
    end
    check(seen > 0, "R2 switch closes", seen, 1);
    check(osc_oe == 1'b1, "R8 oe internal", int'(osc_oe), 1);
  endtask

  task automatic t_small_update();
    for (int k = 0; k <= CH; k++) tgt[k] = CW'(20 * k + 5);
    do_update();
    @(negedge clk);
    check(int'(vcom_code) == 20 * CH + 5, "R10 vcom direct", int'(vcom_code), 20 * CH + 5);
    wait_visits(CH + 1);
    for (int k = 0; k < CH; k++)
      check(obs[k] == 20 * k + 5, "R3 settled within rotation", obs[k], 20 * k + 5);
  endtask

  task automatic t_ignored();
    for (int k = 0; k <= CH; k++) tgt[k] = CW'(1000);
    wait_visits(2 * CH);
    for (int k = 0; k < CH; k++)
      check(obs[k] == 20 * k + 5, "R3 no update ignored", obs[k], 20 * k + 5);
    check(int'(vcom_code) == 20 * CH + 5, "R3 vcom ignored", int'(vcom_code), 20 * CH + 5);
  endtask

  task automatic t_large_step();
    for (int k = 0; k <= CH; k++) tgt[k] = CW'(2047);
    do_update();
    wait_visits(CH);
    check(obs[0] <= 20 + STEP, "R4 first step bounded", obs[0], 20 + STEP);
    wait_visits(6 * CH);
    for (int k = 0; k < CH; k++) check(obs[k] == 2047, "R5 reached top", obs[k], 2047);
    for (int k = 0; k <= CH; k++) tgt[k] = CW'(700);
    do_update();
    wait_visits(5 * CH);
    for (int k = 0; k < CH; k++) check(obs[k] == 700, "R5 reached down", obs[k], 700);
  endtask

  task automatic t_ext_mode();
    int start, n;
    ext_run = 1'b1;
    ext_mode = 1'b1;
    repeat (200) @(negedge clk);
    check(osc_oe == 1'b0, "R7 oe off in external", int'(osc_oe), 0);
    start = visits;
    repeat (400) @(negedge clk);
    n = visits - start;
    check(n >= 9 && n <= 11, "R7 steps follow ext clock", n, 10);
    ext_mode = 1'b0;
    repeat (200) @(negedge clk);
    check(osc_oe == 1'b1, "R8 oe back on", int'(osc_oe), 1);
    ext_run = 1'b0;
    start = visits;
    begin
      int tog = 0; logic last;
      last = osc_out;
      repeat (60) begin
        @(negedge clk);
        if (osc_out != last) tog++;
        last = osc_out;
      end
      check(tog >= 19 && tog <= 21, "R8 osc half period", tog, 20);
    end
    n = visits - start;
    check(n >= 9 && n <= 11, "R1 internal step rate", n, 10);
  endtask

  initial begin
    for (int k = 0; k <= CH; k++) begin tgt[k] = '0; tgt_model[k] = 0; end
    for (int k = 0; k < CH; k++) begin model_app[k] = 0; obs[k] = 0; end
    prev_idx = CH - 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    t_reset();
    t_switches();
    t_small_update();
    t_ignored();
    t_large_step();
    t_ext_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule